// File: doc/BRIEF.md
# eMMC PHY Analog Power Sequencer

This block brings the analog half of an eMMC interface PHY up and down without software polling status bits. A power-on request programs the pad drive strength and the output tap-delay settings. It then resets the calibration circuit, waits a settle time, and releases the calibration circuit. Next it waits for calibration to finish, loads the DLL frequency band, enables the DLL and waits for lock. A power-off request only pulls the calibration power-down-bar low and reports completion.

Both waits have a timeout counted in reference-clock cycles. The calibration wait is short and the lock wait is much longer. On a timeout the sequence aborts with an error and leaves the power-down-bar where it was. The DLL band is taken from the card clock rate, which is given in whole MHz. The rate is rounded to the nearest 50 MHz step and clamped to the top band. A rate above the supported range raises a sticky warning.

Top module: `emmc_phy_pwr_seq`

## Requirements
- R1: After reset, every output is low. This covers phy_pdb, dll_en, dll_freq, drv_type, otap_en, otap_sel, busy, done, err and rate_warn.
- R2: When idle, a power-off request makes phy_pdb and dll_en low one cycle later, with a one-cycle done pulse and busy low. If both requests arrive together, the power-off request wins.
- R3: Once a power-on request is accepted, the next cycle shows the following: drv_type = 6 (the 50 ohm code), otap_en = 0, otap_sel = 4, phy_pdb = 0, dll_en = 0 and busy = 1.
- R4: After an accepted power-on request, phy_pdb stays low for exactly SETTLE_CYC cycles and then rises.
- R5: If cal_done is not seen within CAL_TO_CYC cycles after phy_pdb rises, the sequence ends. done and err are both high for that cycle, busy falls, phy_pdb stays high and dll_en stays low.
- R6: The band is computed as dll_freq = min(3, floor((rate_mhz + 25) / 50)). The codes are 0 = 25 MHz, 1 = 50 MHz, 2 = 100 MHz and 3 = 150 MHz. rate_warn is set when the unclamped value exceeds 3, that is when rate_mhz >= 175. The rate is sampled when the request is accepted.
- R7: dll_freq holds its final value at least one cycle before dll_en rises, and it does not change while dll_en is high.
- R8: When dll_rdy is seen during the lock wait, the sequence ends with done high and err low for one cycle. busy falls, and phy_pdb and dll_en stay high.
- R9: If dll_rdy is not seen within DLL_TO_CYC cycles of dll_en rising, the sequence ends. dll_en is driven low, phy_pdb stays high, and done and err are both high.
- R10: err and rate_warn keep their values until the next request is accepted. An accepted power-off request clears both. An accepted power-on request clears err and loads rate_warn for the new rate.
- R11: Requests that arrive while busy is high are ignored. They do not end the sequence, do not pulse done, and do not change the sampled rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on_req | input | 1 | Start the power-up sequence (taken only when idle) |
| pwr_off_req | input | 1 | Power down the analog blocks (taken only when idle) |
| rate_mhz | input | RATE_W | Card clock rate in MHz |
| cal_done | input | 1 | Calibration finished, from the analog pad circuit |
| dll_rdy | input | 1 | DLL locked |
| phy_pdb | output | 1 | Calibration power-down-bar (low holds the calibration reset) |
| dll_en | output | 1 | DLL enable |
| dll_freq | output | 2 | DLL frequency band code |
| drv_type | output | 3 | Pad drive-type field |
| otap_en | output | 1 | Output tap-delay enable |
| otap_sel | output | 4 | Output tap-delay select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout error |
| rate_warn | output | 1 | Sticky unsupported-rate warning |

## Verification
The bench targets the rate rounding edges on both sides of each 50 MHz midpoint and at the clamp, where an off-by-one compare chain picks the neighbouring band or misses the warning. It measures the low time of the power-down-bar and the length of both timeout windows cycle for cycle, so a counter that ends one cycle early or late shows up as a wrong count. It also checks that the band is stable before the DLL enable rises. It injects both requests, with a new rate, in the middle of a sequence, where a design that does not gate on busy would stop early or change band. It also checks that err and the warning persist while idle and clear on the next accepted request.

// File: rtl/emmc_seq_pkg.sv
package emmc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CALW   = 3'd2,
    ST_FREQ   = 3'd3,
    ST_DLLON  = 3'd4,
    ST_LOCKW  = 3'd5
  } seq_st_e;

  localparam logic [2:0] DRV_50_OHM  = 3'd6;
  localparam logic [3:0] OTAP_SEL_DF = 4'd4;

  // Nearest 50 MHz band, clamped to 3; bit 2 flags a rate past the top band.
  function automatic logic [2:0] rate_to_code(input int unsigned r);
    logic [2:0] res;
    if (r < 25)       res = 3'b0_00;
    else if (r < 75)  res = 3'b0_01;
    else if (r < 125) res = 3'b0_10;
    else if (r < 175) res = 3'b0_11;
    else              res = 3'b1_11;
    return res;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rate_quant.sv
module rate_quant #(
  parameter int RATE_W = 10
) (
  input  logic [RATE_W-1:0] rate,
  output logic [1:0]        code,
  output logic              warn
);
  import emmc_seq_pkg::*;

  logic [2:0] enc;

  always_comb begin
    enc  = rate_to_code(32'(rate));
    code = enc[1:0];
    warn = enc[2];
  end
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == limit - CNT_W'(1));
endmodule

// File: rtl/emmc_phy_pwr_seq.sv
module emmc_phy_pwr_seq #(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int RATE_W      = 10,
  parameter int SETTLE_CYC  = CLK_FREQ_HZ / 200_000,
  parameter int CAL_TO_CYC  = CLK_FREQ_HZ / 20_000,
  parameter int DLL_TO_CYC  = CLK_FREQ_HZ / 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on_req,
  input  logic              pwr_off_req,
  input  logic [RATE_W-1:0] rate_mhz,
  input  logic              cal_done,
  input  logic              dll_rdy,
  output logic              phy_pdb,
  output logic              dll_en,
  output logic [1:0]        dll_freq,
  output logic [2:0]        drv_type,
  output logic              otap_en,
  output logic [3:0]        otap_sel,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              rate_warn
);
  import emmc_seq_pkg::*;

  localparam int unsigned MAX_CYC = max3(SETTLE_CYC, CAL_TO_CYC, DLL_TO_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  seq_st_e st, st_n;
  logic [1:0]       freq_q, freq_code;
  logic             freq_warn;
  logic             tmr_clr, tmr_hit;
  logic [CNT_W-1:0] tmr_lim;

  // Named events for the assertions
  logic on_acc, off_acc, cal_abort, lock_ok, lock_abort, seq_end;

  rate_quant #(.RATE_W(RATE_W)) u_rq (
    .rate (rate_mhz),
    .code (freq_code),
    .warn (freq_warn)
  );

  seq_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .limit (tmr_lim),
    .hit   (tmr_hit)
  );

  assign busy    = (st != ST_IDLE);
  assign off_acc = !busy && pwr_off_req;
  assign on_acc  = !busy && pwr_on_req && !pwr_off_req;

  always_comb begin
    case (st)
      ST_SETTLE: tmr_lim = CNT_W'(SETTLE_CYC);
      ST_CALW:   tmr_lim = CNT_W'(CAL_TO_CYC);
      ST_LOCKW:  tmr_lim = CNT_W'(DLL_TO_CYC);
      default:   tmr_lim = '1;
    endcase
  end

  always_comb begin
    st_n       = st;
    tmr_clr    = 1'b0;
    cal_abort  = 1'b0;
    lock_ok    = 1'b0;
    lock_abort = 1'b0;
    case (st)
      ST_IDLE: begin
        tmr_clr = 1'b1;
        if (on_acc) st_n = ST_SETTLE;
      end
      ST_SETTLE: if (tmr_hit) begin
        st_n    = ST_CALW;
        tmr_clr = 1'b1;
      end
      ST_CALW: begin
        if (cal_done) begin
          st_n = ST_FREQ;
        end else if (tmr_hit) begin
          st_n      = ST_IDLE;
          cal_abort = 1'b1;
        end
      end
      ST_FREQ:  st_n = ST_DLLON;
      ST_DLLON: begin
        st_n    = ST_LOCKW;
        tmr_clr = 1'b1;
      end
      ST_LOCKW: begin
        if (dll_rdy) begin
          st_n    = ST_IDLE;
          lock_ok = 1'b1;
        end else if (tmr_hit) begin
          st_n       = ST_IDLE;
          lock_abort = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign seq_end = busy && (st_n == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      phy_pdb   <= 1'b0;
      dll_en    <= 1'b0;
      dll_freq  <= 2'd0;
      drv_type  <= 3'd0;
      otap_en   <= 1'b0;
      otap_sel  <= 4'd0;
      done      <= 1'b0;
      err       <= 1'b0;
      rate_warn <= 1'b0;
      freq_q    <= 2'd0;
    end else begin
      st   <= st_n;
      done <= 1'b0;
      if (off_acc) begin
        phy_pdb   <= 1'b0;
        dll_en    <= 1'b0;
        done      <= 1'b1;
        err       <= 1'b0;
        rate_warn <= 1'b0;
      end
      if (on_acc) begin
        phy_pdb   <= 1'b0;
        dll_en    <= 1'b0;
        drv_type  <= DRV_50_OHM;
        otap_en   <= 1'b0;
        otap_sel  <= OTAP_SEL_DF;
        err       <= 1'b0;
        rate_warn <= freq_warn;
        freq_q    <= freq_code;
      end
      if (st == ST_SETTLE && tmr_hit) phy_pdb  <= 1'b1;
      if (st == ST_FREQ)              dll_freq <= freq_q;
      if (st == ST_DLLON)             dll_en   <= 1'b1;
      if (lock_ok) done <= 1'b1;
      if (cal_abort || lock_abort) begin
        done   <= 1'b1;
        err    <= 1'b1;
        dll_en <= 1'b0;
      end
    end
  end

  // Checker state: cycles phy_pdb has been low since the last accepted power-on
  logic [CNT_W-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          low_run <= '0;
    else if (on_acc)                     low_run <= '0;
    else if (!phy_pdb && low_run != '1)  low_run <= low_run + 1'b1;
  end

  p_off_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    off_acc |=> (done && !busy && !phy_pdb && !dll_en && !err));

  p_on_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    on_acc |=> (drv_type == DRV_50_OHM && otap_sel == OTAP_SEL_DF && !otap_en
                && !phy_pdb && !dll_en && busy));

  p_settle_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_pdb) |-> (low_run >= CNT_W'(SETTLE_CYC)));

  p_err_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  p_freq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dll_en |=> (!dll_en || $stable(dll_freq)));

  p_dll_needs_pdb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dll_en |-> phy_pdb);

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_end && (pwr_on_req || pwr_off_req)) |=> (busy && !done));

endmodule

// File: tb/emmc_phy_pwr_seq_bench.sv
module emmc_phy_pwr_seq_bench;
  localparam int RATE_W = 10;
  localparam int SETTLE = 8;
  localparam int CAL_TO = 20;
  localparam int DLL_TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on_req = 1'b0, pwr_off_req = 1'b0;
  logic [RATE_W-1:0] rate_mhz = '0;
  logic cal_done = 1'b0, dll_rdy = 1'b0;
  logic phy_pdb, dll_en, otap_en, busy, done, err, rate_warn;
  logic [1:0] dll_freq;
  logic [2:0] drv_type;
  logic [3:0] otap_sel;

  always #2 clk = ~clk;

  emmc_phy_pwr_seq #(
    .CLK_FREQ_HZ (250_000_000),
    .RATE_W      (RATE_W),
    .SETTLE_CYC  (SETTLE),
    .CAL_TO_CYC  (CAL_TO),
    .DLL_TO_CYC  (DLL_TO)
  ) u_emmc_phy_pwr_seq (
    .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
    .rate_mhz(rate_mhz), .cal_done(cal_done), .dll_rdy(dll_rdy),
    .phy_pdb(phy_pdb), .dll_en(dll_en), .dll_freq(dll_freq), .drv_type(drv_type),
    .otap_en(otap_en), .otap_sel(otap_sel), .busy(busy), .done(done), .err(err),
    .rate_warn(rate_warn)
  );

  // Analog models: flags rise a set number of cycles after their enable
  int cal_lat = 3, dll_lat = 5, cal_age = 0, dll_age = 0;
  always @(negedge clk) begin
    if (!phy_pdb) cal_age = 0; else if (cal_age < 100000) cal_age++;
    if (!dll_en)  dll_age = 0; else if (dll_age < 100000) dll_age++;
    cal_done = phy_pdb && (cal_age >= cal_lat);
    dll_rdy  = dll_en && (dll_age >= dll_lat);
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      summary();
    end
  end

  // Results recorded by run_seq
  int low_cnt, cal_cnt, lock_cnt, freq_pre;
  bit got_done, inj_bad;
  logic f_pdb, f_den, f_oen, f_busy, f_err, f_warn;
  logic [2:0] f_drv;
  logic [3:0] f_osel;
  logic d_err, d_pdb, d_den, d_busy, d_warn;
  logic [1:0] d_fq;

  task automatic run_seq(input int rate, input int clat, input int dlat, input bit inject);
    logic prev_en;
    logic [1:0] prev_fq;
    low_cnt = 0; cal_cnt = 0; lock_cnt = 0; freq_pre = -1; got_done = 0; inj_bad = 0;
    cal_lat = clat; dll_lat = dlat; rate_mhz = RATE_W'(rate);
    pwr_on_req = 1'b1;
    @(negedge clk);
    pwr_on_req = 1'b0;
    f_drv = drv_type; f_oen = otap_en; f_osel = otap_sel; f_pdb = phy_pdb;
    f_den = dll_en; f_busy = busy; f_err = err; f_warn = rate_warn;
    prev_en = dll_en; prev_fq = dll_freq;
    for (int i = 0; i < 500; i++) begin
      if (inject && i == 2) begin
        pwr_off_req = 1'b1; pwr_on_req = 1'b1; rate_mhz = RATE_W'(300);
      end
      if (inject && i == 3) begin
        pwr_off_req = 1'b0; pwr_on_req = 1'b0; rate_mhz = RATE_W'(rate);
        if (!busy || done || phy_pdb) inj_bad = 1;
      end
      if (!phy_pdb && busy) low_cnt++;
      if (phy_pdb && busy && !dll_en) cal_cnt++;
      if (dll_en && busy) lock_cnt++;
      if (dll_en && !prev_en) freq_pre = int'(prev_fq);
      prev_en = dll_en; prev_fq = dll_freq;
      if (done) begin
        got_done = 1;
        d_err = err; d_pdb = phy_pdb; d_den = dll_en; d_busy = busy;
        d_fq = dll_freq; d_warn = rate_warn;
        break;
      end
      @(negedge clk);
    end
    chk(got_done, "R8 sequence ends", int'(got_done), 1);
  endtask

  function automatic int exp_code(input int r);
    int q;
    q = (r + 25) / 50;
    return (q > 3) ? 3 : q;
  endfunction

  task automatic t_reset();
    chk(!phy_pdb && !dll_en && dll_freq == 0 && drv_type == 0 && !otap_en &&
        otap_sel == 0 && !busy && !done && !err && !rate_warn,
        "R1 reset outputs", int'({phy_pdb, dll_en, busy, done, err, rate_warn}), 0);
  endtask

  task automatic t_off(input bit both);
    pwr_off_req = 1'b1;
    pwr_on_req = both;
    @(negedge clk);
    pwr_off_req = 1'b0; pwr_on_req = 1'b0;
    chk(done && !busy && !phy_pdb && !dll_en, both ? "R2 off wins" : "R2 off done",
        int'({done, busy, phy_pdb, dll_en}), 8);
    @(negedge clk);
    chk(!done && !busy, "R2 done one cycle", int'({done, busy}), 0);
  endtask

  task automatic t_on_ok();
    run_seq(100, 3, 5, 0);
    chk(f_drv == 3'd6, "R3 drive type", int'(f_drv), 6);
    chk(f_osel == 4'd4 && !f_oen, "R3 tap delay", int'({f_oen, f_osel}), 4);
    chk(!f_pdb && !f_den && f_busy, "R3 pdb low busy", int'({f_pdb, f_den, f_busy}), 1);
    chk(low_cnt == SETTLE, "R4 settle length", low_cnt, SETTLE);
    chk(freq_pre == 2, "R7 freq before enable", freq_pre, 2);
    chk(!d_err && d_pdb && d_den && !d_busy, "R8 lock ok",
        int'({d_err, d_pdb, d_den, d_busy}), 6);
    chk(d_fq == 2'd2, "R6 freq 100", int'(d_fq), 2);
  endtask

  task automatic t_rates();
    int rl[10] = '{0, 24, 25, 74, 75, 124, 125, 174, 175, 400};
    foreach (rl[k]) begin
      run_seq(rl[k], 2, 2, 0);
      chk(int'(d_fq) == exp_code(rl[k]), "R6 band", int'(d_fq), exp_code(rl[k]));
      chk(d_warn == ((rl[k] + 25) / 50 > 3), "R6 warn", int'(d_warn),
          int'((rl[k] + 25) / 50 > 3));
    end
  endtask

  task automatic t_cal_to();
    run_seq(50, 100000, 5, 0);
    chk(cal_cnt == CAL_TO, "R5 cal window", cal_cnt, CAL_TO);
    chk(d_err && d_pdb && !d_den && !d_busy, "R5 cal abort",
        int'({d_err, d_pdb, d_den, d_busy}), 12);
    repeat (5) @(negedge clk);
    chk(err && !done, "R10 err held", int'({err, done}), 2);
    pwr_off_req = 1'b1;
    @(negedge clk);
    pwr_off_req = 1'b0;
    chk(!err, "R10 err cleared", int'(err), 0);
  endtask

  task automatic t_lock_to();
    run_seq(150, 2, 100000, 0);
    chk(lock_cnt == DLL_TO, "R9 lock window", lock_cnt, DLL_TO);
    chk(d_err && d_pdb && !d_den && !d_busy, "R9 lock abort",
        int'({d_err, d_pdb, d_den, d_busy}), 12);
  endtask

  task automatic t_warn_hold();
    run_seq(300, 2, 2, 0);
    chk(d_warn && d_fq == 3, "R6 clamp", int'({d_warn, d_fq}), 7);
    repeat (4) @(negedge clk);
    chk(rate_warn, "R10 warn held", int'(rate_warn), 1);
    run_seq(50, 2, 2, 0);
    chk(!f_warn && !f_err, "R10 warn cleared", int'({f_warn, f_err}), 0);
  endtask

  task automatic t_busy_ignore();
    run_seq(100, 3, 5, 1);
    chk(!inj_bad, "R11 requests ignored", int'(inj_bad), 0);
    chk(low_cnt == SETTLE, "R11 settle intact", low_cnt, SETTLE);
    chk(d_fq == 2'd2 && !d_warn && !d_err, "R11 rate kept",
        int'({d_warn, d_err, d_fq}), 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_off(0);
    t_off(1);
    t_on_ok();
    t_rates();
    t_cal_to();
    t_lock_to();
    t_warn_hold();
    t_busy_ignore();
    summary();
  end
endmodule